// File: doc/BRIEF.md
# Genlock Frame Synchronizer Controller

This block re-times a stream of video pixels onto a local reference timing. On the write side, pixels arrive on the clock recovered from the incoming link, with a frame-start and a line-start marker. A raster counter turns them into addresses in a dual-port frame store. On the read side, a second raster counter runs on the local pixel clock. It is restarted by the reference frame-start and line-start markers, and it fetches stored pixels so that the output moves in step with the reference rather than with the source.

The store is split into a ring of frame slots (four by default). The writer fills one slot at a time and advances to the next slot only when a frame is complete. The count of completed frames crosses into the read clock domain as a Gray code. At every reference frame start, the reader picks the newest complete frame. If nothing new has completed, it plays the same frame again and pulses `o_repeat`. If two or more frames completed since the last choice, the older ones are skipped and `o_drop` pulses. In this way a small rate difference between source and reference never makes the write-to-read distance exceed the store.

Write state machine: `W_SEEK` (waiting for a frame start) goes to `W_FILL` on a frame-start pixel. `W_FILL` returns to `W_SEEK` when the last pixel of the frame is stored. A frame-start pixel seen in `W_FILL` restarts the same slot. Read state machine: `R_EMPTY` (nothing complete yet) goes to `R_PLAY` on the first reference frame start that finds a complete frame. `R_PLAY` stays in place and re-selects a frame at every reference frame start.

Top module: `gsync_frame_sync`

## Requirements
- R1: A stored pixel lands at slot base + line × ACT_PIX + column. The read side returns the pixels of the selected frame in raster order, column 0 first and line 0 first.
- R2: A write pixel (`w_de`=1) is stored only from a pixel flagged `w_sof` onward; pixels before any frame start are ignored. A pixel flagged `w_sol` goes to column 0 of the next line, and `w_sof` takes priority and selects line 0.
- R3: On both sides, pixels whose column is ≥ ACT_PIX or whose line is ≥ ACT_LINES are discarded. They are not written, and on the read side they produce no `o_vld`.
- R4: A frame counts as complete when its last pixel (column ACT_PIX−1, line ACT_LINES−1) is stored. A frame cut short, either by silence or by a new `w_sof`, is never selected for output.
- R5: The completed-frame count crosses to the read clock as a Gray code through two flops. Its code changes by at most one bit per clock on each side.
- R6: At a reference frame start (`ref_de`=1 and `ref_sof`=1), the reader selects the newest complete frame. Before any frame has completed, no `o_vld` is produced.
- R7: If no frame completed since the previous selection, the same frame is read again and `o_repeat` pulses for one cycle.
- R8: If two or more frames completed since the previous selection, the newest is read and `o_drop` pulses for one cycle.
- R9: When exactly one new frame completed, neither pulse is raised. The two pulses are never high together, and each follows a reference frame-start pixel by one read clock.
- R10: `o_vld` and `o_data` for a read request appear one read clock after the `ref_de` pixel that asked for them.
- R11: After reset, `o_vld`, `o_repeat` and `o_drop` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered clock of the incoming stream |
| wrst_n | input | 1 | Active-low reset, write domain |
| w_de | input | 1 | Incoming pixel valid |
| w_sof | input | 1 | Marks the first pixel of an incoming frame |
| w_sol | input | 1 | Marks the first pixel of an incoming line |
| w_data | input | PIX_W | Incoming pixel value |
| rclk | input | 1 | Local pixel clock |
| rrst_n | input | 1 | Active-low reset, read domain |
| ref_de | input | 1 | Reference timing requests a pixel |
| ref_sof | input | 1 | Reference frame start, with the first requested pixel |
| ref_sol | input | 1 | Reference line start, with the first pixel of a line |
| o_vld | output | 1 | Output pixel valid |
| o_data | output | PIX_W | Output pixel value |
| o_repeat | output | 1 | One-cycle pulse: the previous frame is replayed |
| o_drop | output | 1 | One-cycle pulse: intermediate frames were skipped |

## Verification
The checker takes for granted that completed frames are spaced far enough apart that the Gray count cannot step twice between two read-clock samples. It also assumes that a reference frame start always comes on a pixel with `ref_de` high. The stimulus respects both: every frame lasts many clocks on either side, markers are only raised together with their data-enable, and a wait of several read clocks separates the end of a write frame from the reference frame start that is expected to see it. The one overlapping case starts the reference frame a few clocks into a new write frame, so the expected choice stays the previous frame.

// File: rtl/gsync_pkg.sv
package gsync_pkg;

    localparam int FCNT_W = 4;

    typedef logic [FCNT_W-1:0] fcnt_t;

    typedef enum logic {
        W_SEEK,
        W_FILL
    } wr_state_e;

    typedef enum logic {
        R_EMPTY,
        R_PLAY
    } rd_state_e;

    function automatic fcnt_t to_gray(fcnt_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic fcnt_t from_gray(fcnt_t g);
        fcnt_t b;
        b[FCNT_W-1] = g[FCNT_W-1];
        for (int i = FCNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/gsync_raster.sv
// Column/line tracker shared by the write and read sides.
// Out-of-range positions saturate at the geometry limit.
module gsync_raster #(
    parameter int ACT_PIX   = 8,
    parameter int ACT_LINES = 4,
    parameter int X_W       = $clog2(ACT_PIX + 1),
    parameter int Y_W       = $clog2(ACT_LINES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           de,
    input  logic           sof,
    input  logic           sol,
    output logic [X_W-1:0] cur_x,
    output logic [Y_W-1:0] cur_y,
    output logic           in_range
);

    logic [X_W-1:0] nx_q;
    logic [Y_W-1:0] ln_q;

    always_comb begin
        if (sof) begin
            cur_x = '0;
            cur_y = '0;
        end else if (sol) begin
            cur_x = '0;
            cur_y = (ln_q >= Y_W'(ACT_LINES)) ? Y_W'(ACT_LINES) : ln_q + Y_W'(1);
        end else begin
            cur_x = nx_q;
            cur_y = ln_q;
        end
        in_range = (cur_x < X_W'(ACT_PIX)) && (cur_y < Y_W'(ACT_LINES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nx_q <= X_W'(ACT_PIX);
            ln_q <= Y_W'(ACT_LINES);
        end else if (de) begin
            nx_q <= (cur_x >= X_W'(ACT_PIX)) ? X_W'(ACT_PIX) : cur_x + X_W'(1);
            ln_q <= cur_y;
        end
    end

endmodule

// File: rtl/gsync_wr_ctrl.sv
module gsync_wr_ctrl
    import gsync_pkg::*;
#(
    parameter int ACT_PIX   = 8,
    parameter int ACT_LINES = 4,
    parameter int SLOT_BITS = 2,
    parameter int A_W       = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           w_de,
    input  logic           w_sof,
    input  logic           w_sol,
    output logic           we,
    output logic [A_W-1:0] waddr,
    output fcnt_t          done_cnt
);

    localparam int X_W         = $clog2(ACT_PIX + 1);
    localparam int Y_W         = $clog2(ACT_LINES + 1);
    localparam int FRAME_WORDS = ACT_PIX * ACT_LINES;

    wr_state_e      state_q, state_d;
    fcnt_t          done_q, done_d;
    logic [X_W-1:0] cx;
    logic [Y_W-1:0] cy;
    logic           in_rng;
    logic           sof_now;
    logic           last_px;

    gsync_raster #(
        .ACT_PIX  (ACT_PIX),
        .ACT_LINES(ACT_LINES),
        .X_W      (X_W),
        .Y_W      (Y_W)
    ) u_raster (
        .clk     (clk),
        .rst_n   (rst_n),
        .de      (w_de),
        .sof     (w_sof),
        .sol     (w_sol),
        .cur_x   (cx),
        .cur_y   (cy),
        .in_range(in_rng)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_SEEK;
            done_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    // next state and outputs
    always_comb begin
        sof_now = w_de & w_sof;
        we      = w_de & in_rng & ((state_q == W_FILL) | w_sof);
        last_px = we && (cx == X_W'(ACT_PIX - 1)) && (cy == Y_W'(ACT_LINES - 1));
        state_d = state_q;
        unique case (state_q)
            W_SEEK: if (sof_now) state_d = last_px ? W_SEEK : W_FILL;
            W_FILL: if (last_px) state_d = W_SEEK;
        endcase
        done_d   = done_q + fcnt_t'(last_px);
        waddr    = A_W'(done_q[SLOT_BITS-1:0]) * A_W'(FRAME_WORDS)
                 + A_W'(cy) * A_W'(ACT_PIX) + A_W'(cx);
        done_cnt = done_q;
    end

endmodule

// File: rtl/gsync_gray_cdc.sv
module gsync_gray_cdc
    import gsync_pkg::*;
(
    input  logic  wclk,
    input  logic  wrst_n,
    input  logic  rclk,
    input  logic  rrst_n,
    input  fcnt_t bin_in,
    output fcnt_t gray_w,
    output fcnt_t gray_r,
    output fcnt_t bin_out
);

    fcnt_t gw_q, s1_q, s2_q;

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) gw_q <= '0;
        else         gw_q <= to_gray(bin_in);
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gw_q;
            s2_q <= s1_q;
        end
    end

    assign gray_w  = gw_q;
    assign gray_r  = s2_q;
    assign bin_out = from_gray(s2_q);

endmodule

// File: rtl/gsync_rd_ctrl.sv
module gsync_rd_ctrl
    import gsync_pkg::*;
#(
    parameter int ACT_PIX   = 8,
    parameter int ACT_LINES = 4,
    parameter int SLOT_BITS = 2,
    parameter int A_W       = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_de,
    input  logic           ref_sof,
    input  logic           ref_sol,
    input  fcnt_t          avail_cnt,
    output logic           re,
    output logic [A_W-1:0] raddr,
    output logic           o_vld,
    output logic           o_repeat,
    output logic           o_drop
);

    localparam int X_W         = $clog2(ACT_PIX + 1);
    localparam int Y_W         = $clog2(ACT_LINES + 1);
    localparam int FRAME_WORDS = ACT_PIX * ACT_LINES;

    rd_state_e      state_q, state_d;
    fcnt_t          cur_q, cur_d;
    fcnt_t          latest, gap;
    logic           rep_d, drp_d;
    logic           vld_q, rep_q, drp_q;
    logic           sof_now;
    logic [X_W-1:0] cx;
    logic [Y_W-1:0] cy;
    logic           in_rng;

    gsync_raster #(
        .ACT_PIX  (ACT_PIX),
        .ACT_LINES(ACT_LINES),
        .X_W      (X_W),
        .Y_W      (Y_W)
    ) u_raster (
        .clk     (clk),
        .rst_n   (rst_n),
        .de      (ref_de),
        .sof     (ref_sof),
        .sol     (ref_sol),
        .cur_x   (cx),
        .cur_y   (cy),
        .in_range(in_rng)
    );

    // state register and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_EMPTY;
            cur_q   <= '0;
            vld_q   <= 1'b0;
            rep_q   <= 1'b0;
            drp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            vld_q   <= re;
            rep_q   <= rep_d;
            drp_q   <= drp_d;
        end
    end

    // frame choice, next state and outputs
    always_comb begin
        sof_now = ref_de & ref_sof;
        latest  = avail_cnt - fcnt_t'(1);
        gap     = latest - cur_q;
        state_d = state_q;
        cur_d   = cur_q;
        rep_d   = 1'b0;
        drp_d   = 1'b0;
        unique case (state_q)
            R_EMPTY: begin
                if (sof_now && (avail_cnt != '0)) begin
                    state_d = R_PLAY;
                    cur_d   = latest;
                end
            end
            R_PLAY: begin
                if (sof_now) begin
                    cur_d = latest;
                    rep_d = (gap == '0);
                    drp_d = (gap > fcnt_t'(1));
                end
            end
        endcase
        re    = ref_de & in_rng & (state_d == R_PLAY);
        raddr = A_W'(cur_d[SLOT_BITS-1:0]) * A_W'(FRAME_WORDS)
              + A_W'(cy) * A_W'(ACT_PIX) + A_W'(cx);
        o_vld    = vld_q;
        o_repeat = rep_q;
        o_drop   = drp_q;
    end

endmodule

// File: rtl/gsync_frame_store.sv
module gsync_frame_store #(
    parameter int PIX_W = 16,
    parameter int DEPTH = 128,
    parameter int A_W   = 7
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [A_W-1:0]   waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic             rclk,
    input  logic             re,
    input  logic [A_W-1:0]   raddr,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/gsync_frame_sync.sv
module gsync_frame_sync
    import gsync_pkg::*;
#(
    parameter int PIX_W     = 16,
    parameter int ACT_PIX   = 8,
    parameter int ACT_LINES = 4,
    parameter int SLOT_BITS = 2
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             w_de,
    input  logic             w_sof,
    input  logic             w_sol,
    input  logic [PIX_W-1:0] w_data,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic             ref_de,
    input  logic             ref_sof,
    input  logic             ref_sol,
    output logic             o_vld,
    output logic [PIX_W-1:0] o_data,
    output logic             o_repeat,
    output logic             o_drop
);

    localparam int FRAME_WORDS = ACT_PIX * ACT_LINES;
    localparam int DEPTH       = FRAME_WORDS << SLOT_BITS;
    localparam int A_W         = $clog2(DEPTH);

    logic           we, re;
    logic [A_W-1:0] waddr, raddr;
    fcnt_t          done_cnt, avail_cnt, w_gray, r_gray;

    gsync_wr_ctrl #(
        .ACT_PIX  (ACT_PIX),
        .ACT_LINES(ACT_LINES),
        .SLOT_BITS(SLOT_BITS),
        .A_W      (A_W)
    ) u_wr (
        .clk     (wclk),
        .rst_n   (wrst_n),
        .w_de    (w_de),
        .w_sof   (w_sof),
        .w_sol   (w_sol),
        .we      (we),
        .waddr   (waddr),
        .done_cnt(done_cnt)
    );

    gsync_gray_cdc u_cdc (
        .wclk   (wclk),
        .wrst_n (wrst_n),
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .bin_in (done_cnt),
        .gray_w (w_gray),
        .gray_r (r_gray),
        .bin_out(avail_cnt)
    );

    gsync_rd_ctrl #(
        .ACT_PIX  (ACT_PIX),
        .ACT_LINES(ACT_LINES),
        .SLOT_BITS(SLOT_BITS),
        .A_W      (A_W)
    ) u_rd (
        .clk      (rclk),
        .rst_n    (rrst_n),
        .ref_de   (ref_de),
        .ref_sof  (ref_sof),
        .ref_sol  (ref_sol),
        .avail_cnt(avail_cnt),
        .re       (re),
        .raddr    (raddr),
        .o_vld    (o_vld),
        .o_repeat (o_repeat),
        .o_drop   (o_drop)
    );

    gsync_frame_store #(
        .PIX_W(PIX_W),
        .DEPTH(DEPTH),
        .A_W  (A_W)
    ) u_store (
        .wclk (wclk),
        .we   (we),
        .waddr(waddr),
        .wdata(w_data),
        .rclk (rclk),
        .re   (re),
        .raddr(raddr),
        .rdata(o_data)
    );

endmodule

// File: rtl/gsync_checker.sv
module gsync_checker
    import gsync_pkg::*;
(
    input logic  wclk,
    input logic  wrst_n,
    input logic  rclk,
    input logic  rrst_n,
    input logic  ref_de,
    input logic  ref_sof,
    input logic  o_vld,
    input logic  o_repeat,
    input logic  o_drop,
    input fcnt_t w_gray,
    input fcnt_t r_gray
);

    // R9: the two event pulses exclude each other
    assert_no_dual_event_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
        !(o_repeat && o_drop));

    // R9: a repeat pulse follows a reference frame-start pixel
    assert_repeat_after_sof_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
        o_repeat |-> $past(ref_de && ref_sof));

    // R9: a drop pulse follows a reference frame-start pixel
    assert_drop_after_sof_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
        o_drop |-> $past(ref_de && ref_sof));

    // R10: valid output only one clock after a pixel request
    assert_vld_after_de_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
        o_vld |-> $past(ref_de));

    // R5: write-side Gray code moves by one bit at most
    assert_gray_step_w_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    // R5: synchronized Gray code moves by one bit at most
    assert_gray_step_r_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);

endmodule

bind gsync_frame_sync gsync_checker u_chk (
    .wclk    (wclk),
    .wrst_n  (wrst_n),
    .rclk    (rclk),
    .rrst_n  (rrst_n),
    .ref_de  (ref_de),
    .ref_sof (ref_sof),
    .o_vld   (o_vld),
    .o_repeat(o_repeat),
    .o_drop  (o_drop),
    .w_gray  (w_gray),
    .r_gray  (r_gray)
);

// File: tb/tb_gsync_frame_sync.sv
`timescale 1ns/1ps
module tb_gsync_frame_sync;

    localparam int PIX_W     = 16;
    localparam int ACT_PIX   = 8;
    localparam int ACT_LINES = 4;
    localparam int SLOT_BITS = 2;

    logic             wclk = 1'b0, rclk = 1'b0;
    logic             rst_n = 1'b0;
    logic             w_de = 1'b0, w_sof = 1'b0, w_sol = 1'b0;
    logic [PIX_W-1:0] w_data = '0;
    logic             ref_de = 1'b0, ref_sof = 1'b0, ref_sol = 1'b0;
    logic             o_vld, o_repeat, o_drop;
    logic [PIX_W-1:0] o_data;

    int compared   = 0;
    int mismatched = 0;
    int rep_seen   = 0;
    int drp_seen   = 0;
    logic [PIX_W-1:0] exp_q[$];

    always #2.0 rclk = ~rclk;   // 250 MHz reference pixel clock
    always #2.2 wclk = ~wclk;   // slightly slower recovered clock

    gsync_frame_sync #(
        .PIX_W    (PIX_W),
        .ACT_PIX  (ACT_PIX),
        .ACT_LINES(ACT_LINES),
        .SLOT_BITS(SLOT_BITS)
    ) dut (
        .wclk    (wclk),
        .wrst_n  (rst_n),
        .w_de    (w_de),
        .w_sof   (w_sof),
        .w_sol   (w_sol),
        .w_data  (w_data),
        .rclk    (rclk),
        .rrst_n  (rst_n),
        .ref_de  (ref_de),
        .ref_sof (ref_sof),
        .ref_sol (ref_sol),
        .o_vld   (o_vld),
        .o_data  (o_data),
        .o_repeat(o_repeat),
        .o_drop  (o_drop)
    );

    function automatic logic [PIX_W-1:0] pix(int f, int x, int y);
        return {8'(f), 4'(y), 4'(x)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected pixels as the design produces them (R1, R10)
    always @(negedge rclk) begin
        if (rst_n) begin
            if (o_repeat) rep_seen++;
            if (o_drop)   drp_seen++;
            if (o_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R6 unexpected output", int'(o_data), 0);
                end else begin
                    logic [PIX_W-1:0] e;
                    e = exp_q.pop_front();
                    check(o_data == e, "R1/R10 pixel", int'(o_data), int'(e));
                end
            end
        end
    end

    // write driver; npix limits stored pixels, extra adds junk per line, pre adds junk before sof
    task automatic write_frame(int f, int npix, int extra, bit pre);
        int sent = 0;
        bit stop = 0;
        if (pre) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge wclk);
                w_de = 1'b1; w_sof = 1'b0; w_sol = (k == 1); w_data = 16'hDEAD;
            end
        end
        for (int y = 0; y < ACT_LINES; y++) begin
            for (int x = 0; x < ACT_PIX + extra; x++) begin
                if (x < ACT_PIX && sent == npix) stop = 1;
                if (stop) break;
                @(negedge wclk);
                w_de   = 1'b1;
                w_sof  = (x == 0 && y == 0);
                w_sol  = (x == 0);
                w_data = (x < ACT_PIX) ? pix(f, x, y) : 16'hBEEF;
                if (x < ACT_PIX) sent++;
            end
            if (stop) break;
        end
        @(negedge wclk);
        w_de = 1'b0; w_sof = 1'b0; w_sol = 1'b0;
    endtask

    // reference driver and expectation push; checks pulse counts per frame
    task automatic read_frame(int f, int exp_rep, int exp_drp, bit out, int extra, string req);
        int r0 = rep_seen;
        int d0 = drp_seen;
        for (int y = 0; y < ACT_LINES; y++) begin
            for (int x = 0; x < ACT_PIX + extra; x++) begin
                @(negedge rclk);
                if (out && x < ACT_PIX) exp_q.push_back(pix(f, x, y));
                ref_de  = 1'b1;
                ref_sof = (x == 0 && y == 0);
                ref_sol = (x == 0);
            end
        end
        @(negedge rclk);
        ref_de = 1'b0; ref_sof = 1'b0; ref_sol = 1'b0;
        repeat (3) @(negedge rclk);
        check(exp_q.size() == 0, {req, " all pixels out"}, exp_q.size(), 0);
        check(rep_seen - r0 == exp_rep, {req, " repeat pulses"}, rep_seen - r0, exp_rep);
        check(drp_seen - d0 == exp_drp, {req, " drop pulses"}, drp_seen - d0, exp_drp);
        exp_q.delete();
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
    endtask

    initial begin
        repeat (4) @(negedge rclk);
        rst_n = 1'b1;
        @(negedge rclk);
        // R11: reset state
        check(o_vld == 1'b0,    "R11 o_vld",    int'(o_vld), 0);
        check(o_repeat == 1'b0, "R11 o_repeat", int'(o_repeat), 0);
        check(o_drop == 1'b0,   "R11 o_drop",   int'(o_drop), 0);

        // R6: nothing complete yet, no output
        read_frame(0, 0, 0, 1'b0, 0, "R6 empty");

        // R5/R6: first complete frame crosses and is selected, no pulse
        write_frame(1, ACT_PIX * ACT_LINES, 0, 1'b0);
        settle();
        read_frame(1, 0, 0, 1'b1, 0, "R5 R6 first");

        // R7: nothing new, replay with repeat pulse
        read_frame(1, 1, 0, 1'b1, 0, "R7 repeat");

        // R8: three new frames, newest played, drop pulse
        write_frame(2, ACT_PIX * ACT_LINES, 0, 1'b0);
        write_frame(3, ACT_PIX * ACT_LINES, 0, 1'b0);
        write_frame(4, ACT_PIX * ACT_LINES, 0, 1'b0);
        settle();
        read_frame(4, 0, 1, 1'b1, 0, "R8 drop");

        // R9: exactly one new frame, no pulse
        write_frame(5, ACT_PIX * ACT_LINES, 0, 1'b0);
        settle();
        read_frame(5, 0, 0, 1'b1, 0, "R9 one new");

        // R4: a partial frame is never selected
        write_frame(6, 10, 0, 1'b0);
        settle();
        read_frame(5, 1, 0, 1'b1, 0, "R4 partial");

        // R4: partial then restart by a new frame start, full frame wins
        write_frame(9, 13, 0, 1'b0);
        write_frame(6, ACT_PIX * ACT_LINES, 0, 1'b0);
        settle();
        read_frame(6, 0, 0, 1'b1, 0, "R4 restart");

        // R2 R3: junk before sof and past line end is dropped; extra read requests give nothing
        write_frame(7, ACT_PIX * ACT_LINES, 2, 1'b1);
        settle();
        read_frame(7, 0, 0, 1'b1, 2, "R2 R3 junk");

        // R1: read frame 7 while frame 8 is being written into another slot
        fork
            write_frame(8, ACT_PIX * ACT_LINES, 0, 1'b0);
            begin
                repeat (3) @(negedge rclk);
                read_frame(7, 1, 0, 1'b1, 0, "R1 overlap");
            end
        join
        settle();
        read_frame(8, 0, 0, 1'b1, 0, "R9 after overlap");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge rclk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule